// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Engine

This block is the bus-side controller of a 1024-byte serial EEPROM. It watches a two-wire bus (clock and data, both sampled by a fast system clock), picks out start and stop conditions, and compares the header byte with its device code. It answers with acknowledge bits and carries out write and read transfers against a synchronous byte-wide memory port. The data line is driven open-drain: the block only ever pulls it low.

Writes go to the memory port one byte at a time. When a stop follows at least one data byte, the block sends a one-cycle request to a separate commit unit. While that unit reports busy, the block stays silent on its own address, so the master can poll until the commit is done. Reads can start at the current address, at a random address set by a dummy write, or run on sequentially for as long as the master acknowledges.

Top module: `twi_eeprom_slave`

## Requirements
- R1: After reset, `sda_oe_o`, `mem_req_o` and `commit_req_o` are low and the word address counter is 0, so the first current-address read returns byte 0.
- R2: Bus activity seen before any start condition is ignored: a header clocked without a start gets no acknowledge.
- R3: A header is accepted only when bits 7..4 equal 1010 and bit 3 equals `dev_sel_i`. Any other header gets no acknowledge, and the block ignores the bus until the next start.
- R4: In a write transfer the block acknowledges the header, the word-address byte and every data byte by holding SDA low through the ninth clock.
- R5: The write target is header bits 2..1 (as address bits 9..8) joined to the word byte. Each data byte appears as one memory write cycle (`mem_req_o` and `mem_we_o` high for one clock) at that address. In a read header, bits 2..1 are ignored.
- R6: After each written data byte, address bits 3..0 advance modulo 16 and bits 9..4 stay unchanged, so a write of more than 16 bytes overwrites the start of the same page.
- R7: A stop raises `commit_req_o` for exactly one clock if at least one data byte was written since the last start. A stop without data, or a transfer cut short by a repeated start, raises no request.
- R8: While `commit_busy_i` is high when the eighth header bit is sampled, the header is not acknowledged.
- R9: A current-address read returns the byte at the address counter. The counter holds the last accessed address plus one; after a write, that increment is the page-local one of R6.
- R10: A write header plus a word-address byte, followed by a repeated start and a read header, returns the byte at the address just loaded.
- R11: Each master acknowledge in a read sends the next byte. The read increment covers all 10 bits, so the address wraps from 1023 to 0.
- R12: After a master non-acknowledge, the block releases SDA and drives nothing until the next start.
- R13: `sda_oe_o` changes only while SCL is low, one system clock after the synchronized falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8 times the SCL rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level as seen on the wire |
| dev_sel_i | input | 1 | Device strap compared with header bit 3 |
| sda_oe_o | output | 1 | High pulls SDA low |
| mem_req_o | output | 1 | Memory access strobe, one clock per access |
| mem_we_o | output | 1 | Access is a write when high |
| mem_addr_o | output | 10 | Memory byte address |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, valid the clock after the read strobe |
| commit_req_o | output | 1 | One-clock request to commit written data |
| commit_busy_i | input | 1 | Commit unit busy |

## Verification
Two events fall on the same system clock at a page boundary. The memory write for the byte at nibble F goes out at the old address while the counter wraps that nibble to 0. In a sequential read, a master acknowledge at address 1023 starts the prefetch and wraps the full counter to 0 in the same clock. The bench provokes the first with a 20-byte page write starting at nibble C. It judges the result from the queued write addresses and from a following current-address read, which must return the byte at nibble 0. It provokes the second with a random read at 1022 that runs on three bytes, and expects bytes 1022, 1023 and then 0.

// File: rtl/twi_pkg.sv
package twi_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_WADDR,
    ST_WADDR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK
  } twi_state_e;

  localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/twi_sync.sv
module twi_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] pipe_q;
  logic [STAGES-1:0][W-1:0] pipe_d;

  if (STAGES > 1) begin : g_chain
    assign pipe_d = {pipe_q[STAGES-2:0], d_i};
  end else begin : g_single
    assign pipe_d = d_i;
  end

  // idle bus is high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '1;
    else         pipe_q <= pipe_d;
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/twi_bus_cond.sv
module twi_bus_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/twi_addr_ctr.sv
module twi_addr_ctr #(
  parameter int AW        = 10,
  parameter int PAGE_BITS = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          inc_i,
  input  logic          page_wrap_i,
  output logic [AW-1:0] addr_o
);
  localparam logic [AW-1:0]        A_ONE = AW'(1);
  localparam logic [PAGE_BITS-1:0] P_ONE = PAGE_BITS'(1);

  logic [AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
    end else if (load_i) begin
      addr_q <= load_val_i;
    end else if (inc_i) begin
      if (page_wrap_i)
        addr_q <= {addr_q[AW-1:PAGE_BITS], addr_q[PAGE_BITS-1:0] + P_ONE};
      else
        addr_q <= addr_q + A_ONE;
    end
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/twi_eeprom_slave.sv
module twi_eeprom_slave #(
  parameter int AW          = 10,
  parameter int DW          = 8,
  parameter int PAGE_BITS   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic          dev_sel_i,
  output logic          sda_oe_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          commit_req_o,
  input  logic          commit_busy_i
);
  import twi_pkg::*;

  localparam int HI_BITS = AW - DW;
  localparam int BCW     = $clog2(DW);
  localparam logic [BCW-1:0] LAST_BIT = BCW'(DW - 1);
  localparam logic [BCW-1:0] B_ONE    = BCW'(1);

  logic scl_s, sda_s;
  logic scl_rise, scl_fall, start_det, stop_det;

  twi_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   ({scl_s, sda_s})
  );

  twi_bus_cond u_cond (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_s),
    .sda_i     (sda_s),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_det),
    .stop_o    (stop_det)
  );

  twi_state_e        state_q;
  logic [BCW-1:0]    bit_cnt_q;
  logic [DW-2:0]     rx_q;
  logic [DW-1:0]     tx_q;
  logic [HI_BITS-1:0] hi_q;
  logic              byte_end_q, rw_q, wrote_q, ack_ok_q, oe_q;
  logic              mem_req_q, mem_we_q, rd_pend_q, commit_q;
  logic [AW-1:0]     mem_addr_q;
  logic [DW-1:0]     mem_wdata_q;

  logic [DW-1:0] rx_byte;
  logic          hdr_ok, last_bit, bus_evt, rd_fetch, wr_byte, addr_load;
  logic [AW-1:0] ctr_addr;

  always_comb begin
    rx_byte   = {rx_q, sda_s};
    hdr_ok    = (rx_byte[DW-1:DW-4] == DEV_TYPE) && (rx_byte[HI_BITS+1] == dev_sel_i)
                && !commit_busy_i;
    last_bit  = scl_rise && (bit_cnt_q == LAST_BIT) && !byte_end_q;
    bus_evt   = start_det | stop_det;
    rd_fetch  = !bus_evt && ((state_q == ST_DEV && last_bit && hdr_ok && rx_byte[0]) ||
                             (state_q == ST_RACK && scl_rise && !sda_s));
    wr_byte   = !bus_evt && (state_q == ST_WDATA) && last_bit;
    addr_load = !bus_evt && (state_q == ST_WADDR) && last_bit;
  end

  twi_addr_ctr #(.AW(AW), .PAGE_BITS(PAGE_BITS)) u_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (addr_load),
    .load_val_i ({hi_q, rx_byte}),
    .inc_i      (rd_fetch | wr_byte),
    .page_wrap_i(wr_byte),
    .addr_o     (ctr_addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      bit_cnt_q   <= '0;
      rx_q        <= '0;
      tx_q        <= '0;
      hi_q        <= '0;
      byte_end_q  <= 1'b0;
      rw_q        <= 1'b0;
      wrote_q     <= 1'b0;
      ack_ok_q    <= 1'b0;
      oe_q        <= 1'b0;
      mem_req_q   <= 1'b0;
      mem_we_q    <= 1'b0;
      rd_pend_q   <= 1'b0;
      commit_q    <= 1'b0;
      mem_addr_q  <= '0;
      mem_wdata_q <= '0;
    end else begin
      mem_req_q <= 1'b0;
      commit_q  <= 1'b0;
      rd_pend_q <= mem_req_q & ~mem_we_q;
      if (rd_pend_q) tx_q <= mem_rdata_i;

      if (rd_fetch) begin
        mem_req_q  <= 1'b1;
        mem_we_q   <= 1'b0;
        mem_addr_q <= ctr_addr;
      end
      if (wr_byte) begin
        mem_req_q   <= 1'b1;
        mem_we_q    <= 1'b1;
        mem_addr_q  <= ctr_addr;
        mem_wdata_q <= rx_byte;
      end

      if (start_det) begin
        state_q    <= ST_DEV;
        bit_cnt_q  <= '0;
        byte_end_q <= 1'b0;
        oe_q       <= 1'b0;
        wrote_q    <= 1'b0;
      end else if (stop_det) begin
        state_q    <= ST_IDLE;
        byte_end_q <= 1'b0;
        oe_q       <= 1'b0;
        commit_q   <= wrote_q;
        wrote_q    <= 1'b0;
      end else begin
        unique case (state_q)
          ST_IDLE: ;
          ST_DEV, ST_WADDR, ST_WDATA: begin
            if (scl_rise && !byte_end_q) begin
              rx_q <= rx_byte[DW-2:0];
              if (bit_cnt_q != LAST_BIT) begin
                bit_cnt_q <= bit_cnt_q + B_ONE;
              end else if (state_q == ST_DEV) begin
                if (hdr_ok) begin
                  byte_end_q <= 1'b1;
                  rw_q       <= rx_byte[0];
                  if (!rx_byte[0]) hi_q <= rx_byte[HI_BITS:1];
                end else begin
                  state_q <= ST_IDLE;
                end
              end else begin
                byte_end_q <= 1'b1;
                if (state_q == ST_WDATA) wrote_q <= 1'b1;
              end
            end
            if (scl_fall && byte_end_q) begin
              byte_end_q <= 1'b0;
              bit_cnt_q  <= '0;
              oe_q       <= 1'b1;
              state_q    <= (state_q == ST_DEV)   ? ST_DEV_ACK :
                            (state_q == ST_WADDR) ? ST_WADDR_ACK : ST_WDATA_ACK;
            end
          end
          ST_DEV_ACK: begin
            if (scl_fall) begin
              if (rw_q) begin
                state_q <= ST_RDATA;
                oe_q    <= ~tx_q[DW-1];
              end else begin
                state_q <= ST_WADDR;
                oe_q    <= 1'b0;
              end
            end
          end
          ST_WADDR_ACK, ST_WDATA_ACK: begin
            if (scl_fall) begin
              state_q <= ST_WDATA;
              oe_q    <= 1'b0;
            end
          end
          ST_RDATA: begin
            if (scl_fall) begin
              if (bit_cnt_q == LAST_BIT) begin
                oe_q    <= 1'b0;
                state_q <= ST_RACK;
              end else begin
                bit_cnt_q <= bit_cnt_q + B_ONE;
                tx_q      <= tx_q << 1;
                oe_q      <= ~tx_q[DW-2];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) ack_ok_q <= ~sda_s;
            if (scl_fall) begin
              bit_cnt_q <= '0;
              if (ack_ok_q) begin
                state_q <= ST_RDATA;
                oe_q    <= ~tx_q[DW-1];
              end else begin
                state_q <= ST_IDLE;
                oe_q    <= 1'b0;
              end
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign sda_oe_o     = oe_q;
  assign mem_req_o    = mem_req_q;
  assign mem_we_o     = mem_we_q;
  assign mem_addr_o   = mem_addr_q;
  assign mem_wdata_o  = mem_wdata_q;
  assign commit_req_o = commit_q;
endmodule

// File: rtl/twi_eeprom_slave_chk.sv
module twi_eeprom_slave_chk
  import twi_pkg::*;
#(
  parameter int AW        = 10,
  parameter int PAGE_BITS = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          scl_s,
  input logic          sda_oe_o,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          commit_req_o,
  input logic          commit_busy_i,
  input twi_state_e    state_q,
  input logic          byte_end_q,
  input logic [AW-1:0] ctr_addr
);
  logic [AW-PAGE_BITS-1:0] page_ref_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       page_ref_q <= '0;
    else if (state_q == ST_WADDR_ACK)  page_ref_q <= ctr_addr[AW-1:PAGE_BITS];
  end

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !sda_oe_o);  // R2

  AST_WR_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> (state_q == ST_WDATA));  // R5

  AST_PAGE_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> (mem_addr_o[AW-1:PAGE_BITS] == page_ref_q));  // R6

  AST_COMMIT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_req_o |=> !commit_req_o);  // R7

  AST_BUSY_NOACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(byte_end_q) && state_q == ST_DEV) |-> !$past(commit_busy_i));  // R8

  AST_OE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_s);  // R13
endmodule

bind twi_eeprom_slave twi_eeprom_slave_chk #(.AW(AW), .PAGE_BITS(PAGE_BITS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .scl_s        (scl_s),
  .sda_oe_o     (sda_oe_o),
  .mem_req_o    (mem_req_o),
  .mem_we_o     (mem_we_o),
  .mem_addr_o   (mem_addr_o),
  .commit_req_o (commit_req_o),
  .commit_busy_i(commit_busy_i),
  .state_q      (state_q),
  .byte_end_q   (byte_end_q),
  .ctr_addr     (ctr_addr)
);

// File: tb/sim_twi_eeprom_slave.sv
`timescale 1ns/1ps
module sim_twi_eeprom_slave;
  localparam int Q        = 20;
  localparam int BUSY_CYC = 400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_line;
  logic sda_oe, mem_req, mem_we, commit_req, commit_busy;
  logic [9:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic dev_sel = 1'b1;

  assign sda_line = sda_m & ~sda_oe;

  twi_eeprom_slave u0 (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .scl_i        (scl_m),
    .sda_i        (sda_line),
    .dev_sel_i    (dev_sel),
    .sda_oe_o     (sda_oe),
    .mem_req_o    (mem_req),
    .mem_we_o     (mem_we),
    .mem_addr_o   (mem_addr),
    .mem_wdata_o  (mem_wdata),
    .mem_rdata_i  (mem_rdata),
    .commit_req_o (commit_req),
    .commit_busy_i(commit_busy)
  );

  int n_cmp = 0, n_bad = 0, commit_cnt = 0, busy_cnt = 0, ref_ctr = 0;
  logic [7:0] mem [0:1023];
  logic [7:0] ref_mem [0:1023];
  logic [17:0] wq [$];
  logic prev_oe = 1'b0;

  assign commit_busy = (busy_cnt != 0);

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr];
    end
    if (commit_req)        busy_cnt <= BUSY_CYC;
    else if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // per-clock comparison against the queued write model and open-drain timing
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req && mem_we) begin
        if (wq.size() == 0) chk("R5 unexpected write", {mem_addr, mem_wdata}, 0);
        else chk("R5 write addr/data", {mem_addr, mem_wdata}, wq.pop_front());
      end
      if (commit_req) commit_cnt++;
      if (sda_oe != prev_oe) chk("R13 oe change while SCL high", scl_m, 0);
      prev_oe = sda_oe;
    end
  end

  task automatic start_c();
    #Q sda_m = 1'b1; #Q scl_m = 1'b1; #Q sda_m = 1'b0; #Q scl_m = 1'b0;
  endtask

  task automatic stop_c();
    #Q sda_m = 1'b0; #Q scl_m = 1'b1; #Q sda_m = 1'b1; #Q;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      #Q sda_m = b[i]; #Q scl_m = 1'b1; #Q; #Q scl_m = 1'b0;
    end
    #Q sda_m = 1'b1; #Q scl_m = 1'b1; #Q ack = sda_line; #Q scl_m = 1'b0;
  endtask

  task automatic recv_byte(input logic m_ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      #Q sda_m = 1'b1; #Q scl_m = 1'b1; #Q d[i] = sda_line; #Q scl_m = 1'b0;
    end
    #Q sda_m = ~m_ack; #Q scl_m = 1'b1; #Q; #Q scl_m = 1'b0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic a;
    logic [7:0] d;
    for (int i = 0; i < 1024; i++) begin
      mem[i]     = 8'(i * 7 + 3);
      ref_mem[i] = 8'(i * 7 + 3);
    end
    #41 rst_n = 1'b1;
    #10;
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 mem_req", mem_req, 0);
    chk("R1 commit_req", commit_req, 0);

    // R1: counter starts at 0
    start_c(); send_byte(8'hA9, a); chk("R1 hdr ack", a, 0);
    recv_byte(1'b0, d); chk("R1 first read", d, ref_mem[0]); ref_ctr = 1;
    stop_c();

    // R2: header without start
    #Q scl_m = 1'b0;
    send_byte(8'hA8, a); chk("R2 no ack before start", a, 1);
    stop_c();

    // R3: wrong type, then ignored byte, then wrong strap
    start_c(); send_byte(8'hB8, a); chk("R3 wrong type", a, 1);
    send_byte(8'hA8, a); chk("R3 ignored until start", a, 1);
    stop_c();
    start_c(); send_byte(8'hA0, a); chk("R3 wrong strap", a, 1);
    stop_c();

    // R4/R5/R7: byte write to 0x235
    start_c(); send_byte(8'hAC, a); chk("R4 hdr ack", a, 0);
    send_byte(8'h35, a); chk("R4 word ack", a, 0);
    wq.push_back({10'h235, 8'h5A});
    send_byte(8'h5A, a); chk("R4 data ack", a, 0);
    stop_c(); ref_mem[10'h235] = 8'h5A; ref_ctr = 10'h236;
    wait_clk(4);
    chk("R7 commit after write", commit_cnt, 1);
    chk("R5 memory content", mem[10'h235], 8'h5A);

    // R8: poll while busy, then after
    start_c(); send_byte(8'hA8, a); chk("R8 no ack while busy", a, 1);
    stop_c();
    wait_clk(BUSY_CYC + 50);
    start_c(); send_byte(8'hA8, a); chk("R8 ack after busy", a, 0);
    stop_c(); wait_clk(4);
    chk("R7 no commit without data", commit_cnt, 1);

    // R9/R12: current read, then NACK and ignored clocks
    start_c(); send_byte(8'hA9, a); chk("R9 hdr ack", a, 0);
    recv_byte(1'b0, d); chk("R9 current read", d, ref_mem[ref_ctr]); ref_ctr++;
    recv_byte(1'b0, d); chk("R12 released after nack", d, 8'hFF);
    chk("R12 oe low", sda_oe, 0);
    stop_c();

    // R6: 20-byte page write starting at 0x13C
    start_c(); send_byte(8'hAA, a); chk("R6 hdr ack", a, 0);
    send_byte(8'h3C, a); chk("R6 word ack", a, 0);
    for (int i = 0; i < 20; i++) begin
      logic [9:0] wa;
      wa = {6'b010011, 4'((12 + i) % 16)};
      wq.push_back({wa, 8'(8'h80 + i)});
      ref_mem[wa] = 8'(8'h80 + i);
      send_byte(8'(8'h80 + i), a); chk("R6 data ack", a, 0);
    end
    stop_c(); ref_ctr = 10'h130;
    wait_clk(4);
    chk("R7 commit after page", commit_cnt, 2);
    chk("R6 wq drained", wq.size(), 0);
    wait_clk(BUSY_CYC + 50);

    // R9: counter after page wrap
    start_c(); send_byte(8'hA9, a); chk("R9 hdr ack 2", a, 0);
    recv_byte(1'b0, d); chk("R9 read after page wrap", d, ref_mem[ref_ctr]); ref_ctr++;
    stop_c();

    // R10/R11: random read at 0x3FE, sequential across 1023
    start_c(); send_byte(8'hAE, a); chk("R10 dummy hdr", a, 0);
    send_byte(8'hFE, a); chk("R10 word ack", a, 0);
    start_c(); send_byte(8'hA9, a); chk("R10 read hdr", a, 0);
    recv_byte(1'b1, d); chk("R10 random read", d, ref_mem[10'h3FE]);
    recv_byte(1'b1, d); chk("R11 next byte", d, ref_mem[10'h3FF]);
    recv_byte(1'b0, d); chk("R11 wrap to 0", d, ref_mem[0]);
    stop_c(); ref_ctr = 1;
    wait_clk(4);
    chk("R7 no commit after dummy write", commit_cnt, 2);

    start_c(); send_byte(8'hA9, a);
    recv_byte(1'b0, d); chk("R11 counter after wrap", d, ref_mem[ref_ctr]);
    stop_c();

    wait_clk(10);
    finish_run();
  end
endmodule